// File: doc/BRIEF.md
# Flash Control Register Unlock Logic

This block holds the two byte-wide control registers that an embedded flash controller uses to pick its rewrite mode, protect its two blocks against rewriting, and ask for an erase to be suspended. Software reaches both registers over a simple byte bus made of address, write data and write strobe, with read data returned combinationally. The mode, protect and suspend bits are decoded and driven straight to the flash sequencer.

Some bits cannot be changed by a single store. To turn the rewrite mode to its interrupt-driven variant, or to turn on erase suspension, software must write the bit as 0 and then, as its very next bus write, write it as 1. No interrupt may arrive between the two writes. Clearing a block-protect bit works the same way in reverse: 1 first, then 0. A sequence is armed by any write to a register. It is broken by a write to any other address, including the other register, and by an interrupt pulse. A broken sequence leaves the bit as it was.

The suspend-request bit only has meaning while an erase runs with suspension enabled, and it is held at 0 at all other times. In the software-driven mode, software sets and clears it. In the interrupt-driven mode, a maskable interrupt sets it, and software may only clear it.

Top module: `flashctl_top`

## Requirements
- R1: The mode register sits at byte address 0x01B5 with the mode bit at bit 1 and the protect bits for blocks 0 and 1 at bits 6 and 7. The suspend register sits at 0x01B3 with suspend-enable at bit 0, suspend-request at bit 1 and a fixed 1 at bit 6. A read of any other address returns 0x00.
- R2: After reset the mode register reads 0x80 (block 1 protected, everything else 0) and the suspend register reads 0x40. All output bits equal their register bits.
- R3: The mode bit becomes 1 only when a write of 1 to it directly follows a write of 0 to it, with rewriteEn high at the second write. A lone write of 1 leaves it unchanged, and writes to the mode register are ignored while rewriteEn is low.
- R4: The mode bit returns to 0 one cycle after rewriteEn is low, and also on any accepted write of 0.
- R5: The block-protect bits ignore all writes while rewriteEn is low.
- R6: A single write of 1 sets a block-protect bit. A block-protect bit clears only when a write of 0 directly follows a write of 1 to it.
- R7: A pending two-step sequence is cancelled by an irqPulse or by a write to any other address, including the other register. The bit then stays unchanged.
- R8: Suspend-enable becomes 1 only when a write of 1 directly follows a write of 0 with no interrupt between them. A write of 0 clears it.
- R9: Suspend-request is 0 in every cycle that follows one in which suspend-enable and eraseBusy were not both high.
- R10: With the mode bit at 0, software writes set suspend-request to 1 or clear it to 0, provided the condition of R9 holds.
- R11: With the mode bit at 1, an irqPulse sets suspend-request when the condition of R9 holds. A software write of 1 has no effect and a write of 0 clears it. An irqPulse beats a write of 0 in the same cycle.
- R12: Writes to reserved positions have no effect. Reserved bits read 0, except bit 6 of the suspend register, which reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address for reads and writes |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe, one write per cycle |
| rdData | output | 8 | Read data for addr, combinational |
| rewriteEn | input | 1 | Rewrite-mode enable from the flash controller |
| eraseBusy | input | 1 | High while an erase is in progress |
| irqPulse | input | 1 | One-cycle pulse per maskable interrupt |
| modeSel | output | 1 | Rewrite mode: 0 software-driven, 1 interrupt-driven |
| blkProt | output | 2 | Per-block rewrite disable, 1 = disabled |
| suspEnable | output | 1 | Erase-suspend enable |
| suspReq | output | 1 | Erase-suspend request |

## Verification
The checker watches every cycle for the points where hardware alone decides a bit: the mode bit falling after rewriteEn drops, the protect bits holding while rewriteEn is low, the suspend request being forced off outside an enabled erase, an interrupt setting the request in the interrupt-driven mode, and any rise of the mode or suspend-enable bit without a matching write in the cycle before. The unlock sequences need a chain of writes and side events in a set order, so only the bench's scenarios can show them. These include a lone write of 1 failing, a sequence broken by an interrupt or by a write to the other register, a protect bit cleared by 1 then 0, and software being barred from setting the request in the interrupt-driven mode.

// File: rtl/flashctl_pkg.sv
package flashctl_pkg;

  localparam int DATA_W = 8;
  localparam int NUM_BLK = 2;

  // mode register layout
  localparam int MODE_BIT = 1;
  localparam int PROT_LSB = DATA_W - NUM_BLK;
  localparam logic [DATA_W-1:0] MODE_RST = 8'h80;

  // suspend register layout
  localparam int SEN_BIT = 0;
  localparam int SREQ_BIT = 1;
  localparam int FIXED_BIT = 6;
  localparam logic [DATA_W-1:0] SUSP_RST = 8'h40;

  // strobes from the sequence control to the register datapath
  typedef struct packed {
    logic              modeWr;
    logic              suspWr;
    logic              irq;
    logic [DATA_W-1:0] data;
    logic [DATA_W-1:0] rise;   // bit written 1 right after a write of 0
    logic [DATA_W-1:0] fall;   // bit written 0 right after a write of 1
  } regStrobe_t;

endpackage

// File: rtl/flashctl_seq.sv
module flashctl_seq
  import flashctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 16'h01B5,
  parameter logic [ADDR_W-1:0] SUSP_ADDR = 16'h01B3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              irqPulse,
  output regStrobe_t        stb
);

  logic              modeHit;
  logic              suspHit;
  logic              prevValid;
  logic              prevIsMode;
  logic [DATA_W-1:0] prevData;
  logic              chainOk;

  assign modeHit = wrEn && (addr == MODE_ADDR);
  assign suspHit = wrEn && (addr == SUSP_ADDR);

  // the last bus write counts only if no interrupt or other write followed it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevValid  <= 1'b0;
      prevIsMode <= 1'b0;
      prevData   <= '0;
    end else if (irqPulse) begin
      prevValid  <= 1'b0;
    end else if (wrEn) begin
      prevValid  <= modeHit || suspHit;
      prevIsMode <= modeHit;
      prevData   <= wrData;
    end
  end

  assign chainOk = prevValid && !irqPulse &&
                   ((modeHit && prevIsMode) || (suspHit && !prevIsMode));

  always_comb begin
    stb.modeWr = modeHit;
    stb.suspWr = suspHit;
    stb.irq    = irqPulse;
    stb.data   = wrData;
    stb.rise   = chainOk ? (~prevData & wrData) : '0;
    stb.fall   = chainOk ? (prevData & ~wrData) : '0;
  end

endmodule

// File: rtl/flashctl_regs.sv
module flashctl_regs
  import flashctl_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         stb,
  input  logic               rewriteEn,
  input  logic               eraseBusy,
  output logic               modeSel,
  output logic [NUM_BLK-1:0] blkProt,
  output logic               suspEnable,
  output logic               suspReq,
  output logic [DATA_W-1:0]  modeByte,
  output logic [DATA_W-1:0]  suspByte
);

  logic modeAcc;
  logic reqLive;
  logic unusedStb;

  assign modeAcc = stb.modeWr && rewriteEn;
  assign reqLive = suspEnable && eraseBusy;

  // mode select: unlocked by 0 then 1, dropped with rewriteEn
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeSel <= MODE_RST[MODE_BIT];
    end else if (!rewriteEn) begin
      modeSel <= 1'b0;
    end else if (modeAcc) begin
      if (!stb.data[MODE_BIT])
        modeSel <= 1'b0;
      else if (stb.rise[MODE_BIT])
        modeSel <= 1'b1;
    end
  end

  // block protect: set by one write of 1, cleared by 1 then 0
  for (genvar b = 0; b < NUM_BLK; b++) begin : g_prot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        blkProt[b] <= MODE_RST[PROT_LSB+b];
      end else if (modeAcc) begin
        if (stb.data[PROT_LSB+b])
          blkProt[b] <= 1'b1;
        else if (stb.fall[PROT_LSB+b])
          blkProt[b] <= 1'b0;
      end
    end
  end

  // suspend enable: unlocked by 0 then 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      suspEnable <= SUSP_RST[SEN_BIT];
    end else if (stb.suspWr) begin
      if (!stb.data[SEN_BIT])
        suspEnable <= 1'b0;
      else if (stb.rise[SEN_BIT])
        suspEnable <= 1'b1;
    end
  end

  // suspend request: live only during an enabled erase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      suspReq <= SUSP_RST[SREQ_BIT];
    end else if (!reqLive) begin
      suspReq <= 1'b0;
    end else if (modeSel && stb.irq) begin
      suspReq <= 1'b1;
    end else if (stb.suspWr) begin
      if (!stb.data[SREQ_BIT])
        suspReq <= 1'b0;
      else if (!modeSel)
        suspReq <= 1'b1;
    end
  end

  // read images: reserved positions keep their reset values
  always_comb begin
    modeByte = MODE_RST & ~((DATA_W'(1) << MODE_BIT) |
                            (DATA_W'((1 << NUM_BLK) - 1) << PROT_LSB));
    modeByte[MODE_BIT] = modeSel;
    for (int b = 0; b < NUM_BLK; b++) modeByte[PROT_LSB+b] = blkProt[b];
    suspByte = SUSP_RST;
    suspByte[SEN_BIT]  = suspEnable;
    suspByte[SREQ_BIT] = suspReq;
  end

  assign unusedStb = ^{stb.rise, stb.fall, stb.data};

endmodule

// File: rtl/flashctl_top.sv
module flashctl_top
  import flashctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 16'h01B5,
  parameter logic [ADDR_W-1:0] SUSP_ADDR = 16'h01B3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               wrEn,
  output logic [DATA_W-1:0]  rdData,
  input  logic               rewriteEn,
  input  logic               eraseBusy,
  input  logic               irqPulse,
  output logic               modeSel,
  output logic [NUM_BLK-1:0] blkProt,
  output logic               suspEnable,
  output logic               suspReq
);

  regStrobe_t        stb;
  logic [DATA_W-1:0] modeByte;
  logic [DATA_W-1:0] suspByte;

  flashctl_seq #(
    .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR), .SUSP_ADDR(SUSP_ADDR)
  ) u_seq (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData),
    .wrEn(wrEn), .irqPulse(irqPulse), .stb(stb)
  );

  flashctl_regs u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .rewriteEn(rewriteEn),
    .eraseBusy(eraseBusy), .modeSel(modeSel), .blkProt(blkProt),
    .suspEnable(suspEnable), .suspReq(suspReq),
    .modeByte(modeByte), .suspByte(suspByte)
  );

  always_comb begin
    if (addr == MODE_ADDR)      rdData = modeByte;
    else if (addr == SUSP_ADDR) rdData = suspByte;
    else                        rdData = '0;
  end

endmodule

// File: rtl/flashctl_chk.sv
module flashctl_chk
  import flashctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 16'h01B5,
  parameter logic [ADDR_W-1:0] SUSP_ADDR = 16'h01B3
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wrData,
  input logic               wrEn,
  input logic               rewriteEn,
  input logic               eraseBusy,
  input logic               irqPulse,
  input logic               modeSel,
  input logic [NUM_BLK-1:0] blkProt,
  input logic               suspEnable,
  input logic               suspReq
);

  a_r4_mode_drops: assert property (@(posedge clk) disable iff (!rstN)
    !rewriteEn |=> !modeSel);

  a_r3_mode_rise_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeSel) |-> $past(wrEn && addr == MODE_ADDR && wrData[MODE_BIT] && rewriteEn));

  a_r5_prot_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !rewriteEn |=> $stable(blkProt));

  a_r8_en_rise_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(suspEnable) |-> $past(wrEn && addr == SUSP_ADDR && wrData[SEN_BIT] && !irqPulse));

  a_r9_req_forced_low: assert property (@(posedge clk) disable iff (!rstN)
    !(suspEnable && eraseBusy) |=> !suspReq);

  a_r11_irq_sets_req: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel && suspEnable && eraseBusy && irqPulse) |=> suspReq);

endmodule

bind flashctl_top flashctl_chk #(
  .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR), .SUSP_ADDR(SUSP_ADDR)
) u_chk (.*);

// File: tb/sim_flashctl_top.sv
`timescale 1ns/1ps
module sim_flashctl_top;
  import flashctl_pkg::*;

  localparam logic [15:0] A_MODE = 16'h01B5;
  localparam logic [15:0] A_SUSP = 16'h01B3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wrData = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  rdData;
  logic        rewriteEn = 1'b0;
  logic        eraseBusy = 1'b0;
  logic        irqPulse = 1'b0;
  logic        modeSel;
  logic [1:0]  blkProt;
  logic        suspEnable;
  logic        suspReq;

  always #2 clk = ~clk;

  flashctl_top u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdData(rdData), .rewriteEn(rewriteEn), .eraseBusy(eraseBusy),
    .irqPulse(irqPulse), .modeSel(modeSel), .blkProt(blkProt),
    .suspEnable(suspEnable), .suspReq(suspReq)
  );

  typedef struct {
    logic [15:0] a;
    logic [7:0]  expByte;
    logic [4:0]  expOut;
    string       tag;
  } item_t;

  item_t q[$];
  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  // expected state, updated by hand from the requirements
  logic mMode = 0, mP0 = 0, mP1 = 1, mEn = 0, mReq = 0;

  function automatic logic [4:0] expOuts();
    return {mMode, mP1, mP0, mEn, mReq};
  endfunction

  task automatic push(input logic [15:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.a = a; it.expByte = e; it.expOut = expOuts(); it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic chk(input string tag);
    push(A_MODE, {mP1, mP0, 4'b0000, mMode, 1'b0}, tag);
    push(A_SUSP, {1'b0, 1'b1, 4'b0000, mReq, mEn}, tag);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic irq();
    @(negedge clk);
    irqPulse = 1'b1;
    @(negedge clk);
    irqPulse = 1'b0;
  endtask

  // monitor: presents each expected item on the bus and compares
  initial begin
    forever begin
      wait (q.size() > 0);
      @(negedge clk);
      addr = q[0].a;
      #1;
      nRun++;
      if (rdData !== q[0].expByte ||
          {modeSel, blkProt, suspEnable, suspReq} !== q[0].expOut) begin
        nFail++;
        $display("FAIL %s addr=%h rd=%h exp=%h out=%b exp=%b", q[0].tag, q[0].a,
                 rdData, q[0].expByte, {modeSel, blkProt, suspEnable, suspReq},
                 q[0].expOut);
      end
      void'(q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R2 reset values");
    push(16'h0000, 8'h00, "R1 unmapped read");

    // rewriteEn low: protect and mode writes ignored
    wr(A_MODE, 8'h80); wr(A_MODE, 8'h00);
    wr(A_MODE, 8'h00); wr(A_MODE, 8'h02);
    chk("R5 writes ignored without rewriteEn");

    rewriteEn = 1'b1;
    wr(A_MODE, 8'h02);
    chk("R3 lone write of 1 leaves mode");
    wr(A_MODE, 8'h80); wr(A_MODE, 8'h82);
    mMode = 1; chk("R3 mode set by 0 then 1");

    wr(A_MODE, 8'h82); wr(A_MODE, 8'h02);
    mP1 = 0; chk("R6 protect cleared by 1 then 0");
    wr(A_MODE, 8'h42);
    mP0 = 1; chk("R6 protect set by single 1");

    wr(A_MODE, 8'h40);
    mMode = 0; chk("R4 write of 0 clears mode");
    irq();
    wr(A_MODE, 8'h42);
    chk("R7 interrupt aborts mode sequence");
    wr(A_MODE, 8'h40); wr(A_SUSP, 8'h00); wr(A_MODE, 8'h42);
    chk("R7 other-register write aborts sequence");

    wr(A_MODE, 8'h40); wr(A_MODE, 8'h42);
    mMode = 1; chk("R3 mode set again");
    @(negedge clk); rewriteEn = 1'b0;
    repeat (2) @(negedge clk);
    mMode = 0; chk("R4 mode drops with rewriteEn");
    rewriteEn = 1'b1;

    wr(A_MODE, 8'h7D);
    wr(A_SUSP, 8'hBC);
    chk("R12 reserved bits ignore writes");

    irq();
    wr(A_SUSP, 8'h01);
    chk("R7 interrupt blocks suspend enable");
    wr(A_SUSP, 8'h00); wr(A_SUSP, 8'h01);
    mEn = 1; chk("R8 suspend enable by 0 then 1");

    wr(A_SUSP, 8'h03);
    chk("R9 request held low without erase");

    @(negedge clk); eraseBusy = 1'b1;
    wr(A_SUSP, 8'h03);
    mReq = 1; chk("R10 software sets request");
    wr(A_SUSP, 8'h01);
    mReq = 0; chk("R10 software clears request");
    wr(A_SUSP, 8'h03);
    mReq = 1; chk("R10 request set again");
    @(negedge clk); eraseBusy = 1'b0;
    @(negedge clk);
    mReq = 0; chk("R9 request drops at erase end");
    eraseBusy = 1'b1;

    wr(A_MODE, 8'h40); wr(A_MODE, 8'h42);
    mMode = 1; chk("R3 interrupt-driven mode entered");
    wr(A_SUSP, 8'h03);
    chk("R11 software write of 1 ignored");
    irq();
    mReq = 1; chk("R11 interrupt sets request");
    wr(A_SUSP, 8'h01);
    mReq = 0; chk("R11 write of 0 clears request");

    // interrupt and write of 0 in the same cycle
    @(negedge clk);
    addr = A_SUSP; wrData = 8'h01; wrEn = 1'b1; irqPulse = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; irqPulse = 1'b0;
    mReq = 1; chk("R11 interrupt beats write of 0");

    wr(A_SUSP, 8'h00);
    mEn = 0; mReq = 0; chk("R8 write of 0 clears enable");
    irq();
    chk("R9 interrupt ignored while disabled");

    @(negedge clk); rewriteEn = 1'b0;
    wr(A_MODE, 8'hC2);
    mMode = 0; chk("R5 protect write ignored, mode dropped");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule